// File: doc/BRIEF.md
# Serial Bit-Rate Tick Generator

This block derives the bit-time strobe of an asynchronous serial controller from the bus clock. Software writes one byte-wide configuration register. Two packed fields in that byte pick a division ratio. The first is a prescale factor of 1, 3, 4 or 13. The block multiplies that factor by a fixed oversampling constant of 16, then scales it by a power of two from 1 to 128. The result is the number of bus cycles in one serial bit.

The block has two outputs. The first is a one-cycle `tick` pulse, once per bit time. The second is the bit period itself, given in bus cycles, so that a neighbouring character timer can count whole frames. A write to the register restarts the tick counter, so the new rate applies from the next bit on. The remaining bits of the byte are test-mode bits. They are held and read back, but they do nothing. Reset loads one of two register values. A normal reset gives the fastest rate. A reset taken in boot mode gives the preset that yields 1200 baud from a 2 MHz bus clock.

Top module: `baud_tick_gen`

## Requirements
- R1: While `rst` is high with `boot_mode` low, the register resets to 0x00. One cycle later `bit_period` reads 16 and `tick` stays low.
- R2: While `rst` is high with `boot_mode` high, the register resets to 0x33. `bit_period` then reads 1664 (13 x 16 x 8).
- R3: Bits [5:4] of the register select the prescale factor: 00 gives 1, 01 gives 3, 10 gives 4 and 11 gives 13. This factor is multiplied by 16.
- R4: Bits [2:0] of the register hold N. They multiply the divisor by 2^N, for N from 0 to 7, so the largest divisor is 26624.
- R5: `bit_period` shows the new divisor from the second rising edge after the write edge, and keeps that value while the register is unchanged.
- R6: `tick` is high for exactly one cycle per bit time. Successive pulses are exactly `bit_period` cycles apart.
- R7: A write restarts the counter. `tick` is low in the cycle after the write edge. The first pulse comes D edges after the write edge, where D is the new divisor.
- R8: Bits 7, 6 and 3 are stored and read back on `cfg_rd`. They have no effect on `bit_period` or on tick timing.
- R9: After reset is released, the first `tick` comes D edges after the last reset edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode | input | 1 | Selects the boot preset as the reset value of the register |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| cfg_rd | output | 8 | Current register contents |
| bit_period | output | 15 | Bus cycles per serial bit (registered) |
| tick | output | 1 | One-cycle pulse once per bit time |

## Verification
The assertions check four things on every cycle:
- both reset values;
- that a write forces the strobe low on the next cycle;
- that the strobe never lasts two cycles;
- that `bit_period` does not move while the register is steady.

Only the bench's scenarios can show that the pulse spacing equals the decoded divisor. The bench sweeps every combination of the prescale and rate fields, and checks the extreme divisor of 26624. Those scenarios also show that the test-mode bits leave the timing alone.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int REG_W     = 8;
  localparam int PRESC_W   = 2;
  localparam int RATE_W    = 3;
  localparam int PRESC_LSB = 4;
  localparam int RATE_LSB  = 0;
  localparam int OVS       = 16;
  localparam int MAX_PRE   = 13;
  localparam int MAX_SHIFT = (1 << RATE_W) - 1;
  localparam int MAX_DIV   = MAX_PRE * OVS * (1 << MAX_SHIFT);
  localparam int DIV_W     = $clog2(MAX_DIV + 1);
  localparam logic [REG_W-1:0] RST_CFG  = 8'h00;
  localparam logic [REG_W-1:0] BOOT_CFG = 8'h33;

  function automatic logic [DIV_W-1:0] presc_factor(input logic [PRESC_W-1:0] sel);
    case (sel)
      2'd0:    presc_factor = DIV_W'(1);
      2'd1:    presc_factor = DIV_W'(3);
      2'd2:    presc_factor = DIV_W'(4);
      default: presc_factor = DIV_W'(MAX_PRE);
    endcase
  endfunction

  function automatic logic [DIV_W-1:0] cfg_divisor(input logic [REG_W-1:0] cfg);
    logic [PRESC_W-1:0] p;
    logic [RATE_W-1:0]  r;
    p = cfg[PRESC_LSB +: PRESC_W];
    r = cfg[RATE_LSB +: RATE_W];
    cfg_divisor = (presc_factor(p) * DIV_W'(OVS)) << r;
  endfunction
endpackage

// File: rtl/baud_cfg_reg.sv
module baud_cfg_reg
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)        cfg_q <= boot_mode ? BOOT_CFG : RST_CFG;
    else if (wr_en) cfg_q <= wr_data;
  end
endmodule

// File: rtl/baud_div_decode.sv
module baud_div_decode
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_mode,
  input  logic [REG_W-1:0] cfg,
  output logic [DIV_W-1:0] div_now,
  output logic [DIV_W-1:0] period_q
);
  assign div_now = cfg_divisor(cfg);

  always_ff @(posedge clk) begin
    if (rst) period_q <= cfg_divisor(boot_mode ? BOOT_CFG : RST_CFG);
    else     period_q <= div_now;
  end
endmodule

// File: rtl/baud_tick_ctr.sv
module baud_tick_ctr
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic [DIV_W-1:0] div,
  output logic             tick_q
);
  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div - DIV_W'(1));

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      tick_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + DIV_W'(1);
      tick_q <= 1'b0;
    end
  end
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             boot_mode,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] cfg_rd,
  output logic [DIV_W-1:0] bit_period,
  output logic             tick
);
  logic [REG_W-1:0] cfg_q;
  logic [DIV_W-1:0] div_now;

  baud_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .boot_mode(boot_mode),
    .wr_en(wr_en), .wr_data(wr_data), .cfg_q(cfg_q)
  );

  baud_div_decode u_dec (
    .clk(clk), .rst(rst), .boot_mode(boot_mode),
    .cfg(cfg_q), .div_now(div_now), .period_q(bit_period)
  );

  baud_tick_ctr u_ctr (
    .clk(clk), .rst(rst), .restart(wr_en),
    .div(div_now), .tick_q(tick)
  );

  assign cfg_rd = cfg_q;
endmodule

// File: rtl/baud_tick_gen_chk.sv
module baud_tick_gen_chk
  import baud_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             boot_mode,
  input logic             wr_en,
  input logic [REG_W-1:0] cfg_rd,
  input logic [DIV_W-1:0] bit_period,
  input logic             tick
);
  // R1
  plain_reset_chk: assert property (@(posedge clk)
    (rst && !boot_mode) |=> (cfg_rd == 8'h00 && !tick));

  // R2
  boot_reset_chk: assert property (@(posedge clk)
    (rst && boot_mode) |=> (cfg_rd == 8'h33));

  // R7
  wr_restart_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> !tick);

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  // R5
  period_hold_chk: assert property (@(posedge clk) disable iff (rst)
    ($stable(cfg_rd) && !$past(rst)) |=> $stable(bit_period));
endmodule

bind baud_tick_gen baud_tick_gen_chk u_chk (
  .clk(clk), .rst(rst), .boot_mode(boot_mode), .wr_en(wr_en),
  .cfg_rd(cfg_rd), .bit_period(bit_period), .tick(tick)
);

// File: tb/baud_tick_gen_tb.sv
module baud_tick_gen_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        boot_mode = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  cfg_rd;
  logic [14:0] bit_period;
  logic        tick;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  baud_tick_gen u_dut (
    .clk(clk), .rst(rst), .boot_mode(boot_mode), .wr_en(wr_en),
    .wr_data(wr_data), .cfg_rd(cfg_rd), .bit_period(bit_period), .tick(tick)
  );

  function automatic int exp_div(input logic [7:0] v);
    int pf;
    case (v[5:4])
      2'd0: pf = 1;
      2'd1: pf = 3;
      2'd2: pf = 4;
      default: pf = 13;
    endcase
    return pf * 16 * (1 << v[2:0]);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write at one edge; returns at the negedge just after the write edge
  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // called at the negedge just after a restart edge; k counts edges since it
  task automatic measure(input string req, input int d);
    int first = -1, second = -1, highs = 0;
    check({req, " tick low after restart"}, int'(tick), 0);
    for (int k = 1; k <= 2*d + 1; k++) begin
      @(negedge clk);
      if (tick) begin
        highs++;
        if (first < 0) first = k;
        else if (second < 0) second = k;
      end
    end
    check({req, " first tick"}, first, d);
    check({req, " second tick"}, second, 2*d);
    check({req, " pulse count"}, highs, 2);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 plain reset state
    check("R1 cfg", int'(cfg_rd), 0);
    check("R1 period", int'(bit_period), 16);
    check("R1 tick", int'(tick), 0);
    rst = 1'b0;
    // R9 first tick after reset release (last reset edge was before this negedge)
    measure("R9", 16);

    // R3 R4 R5 R6 R7 sweep over fields
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 8; r++) begin
        logic [7:0] v;
        v = {2'b00, 2'(p), 1'b0, 3'(r)};
        write_cfg(v);
        if (r <= 5) begin
          measure("R6 R7 sweep", exp_div(v));
          check("R3 R4 R5 period", int'(bit_period), exp_div(v));
        end else begin
          @(negedge clk);
          check("R4 R5 period high shift", int'(bit_period), exp_div(v));
        end
      end
    end

    // R4 largest divisor timing
    write_cfg(8'h37);
    measure("R4 max", 26624);
    check("R4 max period", int'(bit_period), 26624);

    // R8 test bits stored and inert
    write_cfg(8'hC8);
    check("R8 readback", int'(cfg_rd), 8'hC8);
    measure("R8 timing", 16);
    check("R8 period", int'(bit_period), 16);
    write_cfg(8'hFA);
    check("R8 readback2", int'(cfg_rd), 8'hFA);
    measure("R8 timing2", exp_div(8'h32));

    // R7 restart mid-bit
    write_cfg(8'h10);
    repeat (20) @(negedge clk);
    write_cfg(8'h10);
    measure("R7 mid-bit restart", 48);

    // R2 boot reset
    @(negedge clk);
    boot_mode = 1'b1; rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R2 cfg", int'(cfg_rd), 8'h33);
    check("R2 period", int'(bit_period), 1664);
    rst = 1'b0;
    measure("R2 R9 boot timing", 1664);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule